// File: doc/BRIEF.md
# Single-Wire Activation Pattern Detector

This block listens to one open-drain debug data line and decides when a host has sent the wake-up pattern that switches the debug interface on. The pattern is a run of slow pulses followed by a run of pulses at twice that rate. The line is sampled on the fast system clock. Each edge is stamped with the value of a free-running cycle counter. The block compares pulse lengths with each other and never with an absolute frequency, so it works with any host oscillator accuracy.

Lengths are taken on every edge, from the edge two positions back to the current one. The first length of a candidate becomes the reference. The following slow pulses must lie close to that reference. The reference is then halved for the fast run. When the last fast pulse matches, the block raises a one-cycle strobe and reports the time stamp where the candidate began. It then returns to idle. Bit decoding and driving the line are handled elsewhere.

Top module: `entseq_detect`

## Requirements
- R1: The line passes through a two-flop synchroniser. An input change applied in the cycle where the counter reads c is stamped with the time c+2.
- R2: The time stamp counter starts at 0 in the first cycle after reset release and goes up by one per clock. It stops at all ones (CNT_W bits) and never wraps.
- R3: Once two edges have been seen since reset, every further edge gives a length: the stamp of the current edge minus the stamp of the edge two positions earlier.
- R4: In the idle state, a length becomes the reference. The stamp of its earlier edge becomes the candidate start.
- R5: A length that differs from the reference by at most 2 matches. A difference of 3 or more is a mismatch. The first slow length plus three more matching ones make up the slow run of four.
- R6: After the fourth slow match, the reference is replaced by itself shifted right by one (floor of half). The four fast lengths are compared against this halved value, so fast lengths equal to the slow ones fail.
- R7: A mismatch in either run drops the candidate. The current length at once becomes the new reference, and its earlier edge becomes the new start.
- R8: On the fourth fast match, `entered_o` is high for exactly one cycle. `entry_start_o` then shows the candidate start, and the block goes back to idle.
- R9: A synchronous reset clears the counter, the edge history, the candidate progress and the reference. It also holds `entered_o` low, so a pattern cut by a reset is never reported.
- R10: A mismatch in the fast run produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System sampling clock |
| rst_i | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Asynchronous debug data line, idle high |
| entered_o | output | 1 | One-cycle strobe: activation pattern recognised |
| entry_start_o | output | CNT_W | Time stamp of the edge that began the recognised pattern |

## Verification
Faults in the internal state can only appear through the strobe and the reported start stamp. A wrong edge history or time base changes the stamp reported as soon as the next pattern completes. A reference that is not halved, or halved at the wrong time, makes every legal pattern fail on its fifth length. A broken tolerance shows up on the boundary patterns that sit exactly 2 or 3 samples off. A bad restart rule moves the reported start on patterns that follow junk pulses, so each such fault becomes visible within one pattern of about 200 cycles.

// File: rtl/entseq_pkg.sv
package entseq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SLOW = 2'd1,
      PH_FAST = 2'd2
   } phase_e;

endpackage

// File: rtl/entseq_sync.sv
module entseq_sync #(
   parameter int STAGES   = 2,
   parameter bit IDLE_LVL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic line_i,
   output logic level_o,
   output logic edge_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("entseq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i) begin
            if (rst_i) chain_q[s] <= IDLE_LVL;
            else       chain_q[s] <= line_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i) begin
            if (rst_i) chain_q[s] <= IDLE_LVL;
            else       chain_q[s] <= chain_q[s-1];
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) prev_q <= IDLE_LVL;
      else       prev_q <= chain_q[STAGES-1];
   end

   assign level_o = chain_q[STAGES-1];
   assign edge_o  = chain_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/entseq_stamp.sv
module entseq_stamp #(
   parameter int CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_i,
   output logic [CNT_W-1:0] stamp_o
);

   if (CNT_W < 4) begin : g_bad_width
      $error("entseq_stamp: CNT_W must be at least 4");
   end

   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)             cnt_q <= '0;
      else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
   end

   assign stamp_o = cnt_q;

   // R2
   stamp_mono_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      stamp_o >= $past(stamp_o));

   // R2
   stamp_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (stamp_o == TOP) |=> (stamp_o == TOP));

endmodule

// File: rtl/entseq_match.sv
module entseq_match
   import entseq_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int TOL         = 2,
   parameter int SLOW_PULSES = 4,
   parameter int FAST_PULSES = 4
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             edge_i,
   input  logic [CNT_W-1:0] stamp_i,
   output logic             found_o,
   output logic [CNT_W-1:0] start_o
);

   if (SLOW_PULSES < 2 || FAST_PULSES < 1) begin : g_bad_runs
      $error("entseq_match: need SLOW_PULSES >= 2 and FAST_PULSES >= 1");
   end
   if (TOL < 0) begin : g_bad_tol
      $error("entseq_match: TOL must not be negative");
   end

   localparam int RUN_MAX = (SLOW_PULSES > FAST_PULSES) ? SLOW_PULSES : FAST_PULSES;
   localparam int RW      = $clog2(RUN_MAX + 1);
   localparam logic [RW-1:0]    SLOW_LAST = RW'(SLOW_PULSES - 1);
   localparam logic [RW-1:0]    FAST_LAST = RW'(FAST_PULSES - 1);
   localparam logic [CNT_W-1:0] TOL_V     = CNT_W'(TOL);

   // edge history: newest and the one before it
   logic [CNT_W-1:0] e_new_q, e_old_q;
   logic [1:0]       hist_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         e_new_q <= '0;
         e_old_q <= '0;
         hist_q  <= '0;
      end else if (edge_i) begin
         e_old_q <= e_new_q;
         e_new_q <= stamp_i;
         if (hist_q != 2'd2) hist_q <= hist_q + 2'd1;
      end
   end

   logic             meas;
   logic [CNT_W-1:0] len;
   assign meas = edge_i && (hist_q == 2'd2);
   assign len  = stamp_i - e_old_q;

   phase_e           phase_q;
   logic [RW-1:0]    run_q;
   logic [CNT_W-1:0] ref_q;
   logic [CNT_W-1:0] cand_q;
   logic [CNT_W-1:0] diff;
   logic             close;

   assign diff  = (len >= ref_q) ? (len - ref_q) : (ref_q - len);
   assign close = (diff <= TOL_V);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         phase_q <= PH_IDLE;
         run_q   <= '0;
         ref_q   <= '0;
         cand_q  <= '0;
         found_o <= 1'b0;
         start_o <= '0;
      end else begin
         found_o <= 1'b0;
         if (meas) begin
            if (phase_q == PH_IDLE || !close) begin
               ref_q   <= len;
               cand_q  <= e_old_q;
               phase_q <= PH_SLOW;
               run_q   <= RW'(1);
            end else if (phase_q == PH_SLOW) begin
               if (run_q == SLOW_LAST) begin
                  ref_q   <= ref_q >> 1;
                  phase_q <= PH_FAST;
                  run_q   <= '0;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end else begin
               if (run_q == FAST_LAST) begin
                  found_o <= 1'b1;
                  start_o <= cand_q;
                  phase_q <= PH_IDLE;
                  run_q   <= '0;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end
         end
      end
   end

   // R8
   strobe_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      found_o |=> !found_o);

   // R8
   strobe_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      found_o |-> $past(meas));

   // R8
   idle_after_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      found_o |-> (phase_q == PH_IDLE));

   // R9
   reset_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rst_i) |-> (!found_o && phase_q == PH_IDLE && ref_q == '0));

   // R3
   hist_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase_q != PH_IDLE) |-> (hist_q == 2'd2));

endmodule

// File: rtl/entseq_detect.sv
module entseq_detect #(
   parameter int CNT_W       = 32,
   parameter int SYNC_STAGES = 2,
   parameter int TOL         = 2,
   parameter int SLOW_PULSES = 4,
   parameter int FAST_PULSES = 4
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             line_i,
   output logic             entered_o,
   output logic [CNT_W-1:0] entry_start_o
);

   logic             lvl;
   logic             edg;
   logic [CNT_W-1:0] stamp;

   entseq_sync #(
      .STAGES   (SYNC_STAGES),
      .IDLE_LVL (1'b1)
   ) u_sync (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .line_i  (line_i),
      .level_o (lvl),
      .edge_o  (edg)
   );

   entseq_stamp #(
      .CNT_W (CNT_W)
   ) u_stamp (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .stamp_o (stamp)
   );

   entseq_match #(
      .CNT_W       (CNT_W),
      .TOL         (TOL),
      .SLOW_PULSES (SLOW_PULSES),
      .FAST_PULSES (FAST_PULSES)
   ) u_match (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .edge_i  (edg),
      .stamp_i (stamp),
      .found_o (entered_o),
      .start_o (entry_start_o)
   );

   logic unused_lvl;
   assign unused_lvl = lvl;

   // R1
   edge_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      edg |-> (lvl != $past(lvl)));

endmodule

// File: tb/sim_entseq_detect.sv
`timescale 1ns/1ps
module sim_entseq_detect;

   localparam int NV  = 7;
   localparam int LAT = 2;

   // half-period intervals per vector (cycles between successive toggles)
   localparam int VH [NV][12] = '{
      '{20,20,20,20,19, 2,18, 2,18, 0, 0, 0},   // legal pattern
      '{20,20,25,20,20,19, 2,18, 2, 0, 0, 0},   // slow run broken
      '{20,20,20,20,19, 2,18, 2,25, 0, 0, 0},   // fast run broken
      '{20,20,22,18,21, 1,19, 1,19, 0, 0, 0},   // +2 accepted in both runs
      '{20,20,23,17,20,19, 2,18, 2, 0, 0, 0},   // +3 rejected
      '{20,20,20,20,20,20,20,20,20, 0, 0, 0},   // no speed-up: rejected
      '{ 7, 5,20,20,20,20,19, 2,18, 2,18, 0}    // junk then legal
   };
   localparam int VN   [NV] = '{9, 9, 9, 9, 9, 9, 11};
   localparam int VDET [NV] = '{1, 0, 0, 1, 0, 0, 1};
   localparam int VSI  [NV] = '{0, 0, 0, 0, 0, 0, 2};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        line = 1'b1;
   logic        ent0, ent1;
   logic [31:0] st0;
   logic [7:0]  st1;

   always #2 clk = ~clk;

   entseq_detect u0 (
      .clk_i (clk), .rst_i (rst), .line_i (line),
      .entered_o (ent0), .entry_start_o (st0)
   );

   entseq_detect #(.CNT_W(8)) u1 (
      .clk_i (clk), .rst_i (rst), .line_i (line),
      .entered_o (ent1), .entry_start_o (st1)
   );

   int     checks = 0;
   int     errors = 0;
   longint bc = 0;
   int     n0 = 0, n1 = 0;
   longint last0 = 0, last1 = 0;
   longint stamps [0:15];
   int     ne = 0;
   bit     done = 1'b0;

   always @(posedge clk) bc <= rst ? 0 : bc + 1;

   always @(negedge clk) begin
      if (ent0) begin n0 <= n0 + 1; last0 <= st0; end
      if (ent1) begin n1 <= n1 + 1; last1 <= st1; end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tog();
      line = ~line;
      stamps[ne] = bc;
      ne++;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int b0, b1;
      idle(4);
      rst = 1'b0;
      idle(2);
      chk(ent0 == 1'b0, "R9", "entered after reset", ent0, 0);
      chk(st0 == 0, "R9", "start after reset", st0, 0);

      // table walk: R3 R4 R5 R6 R7 R8 R10, stamps per R1 R2
      for (int v = 0; v < NV; v++) begin
         b0 = n0;
         ne = 0;
         tog();
         for (int i = 0; i < VN[v]; i++) begin
            idle(VH[v][i]);
            tog();
         end
         idle(60);
         chk((n0 - b0) == VDET[v], "R5 R6 R7 R8 R10",
             $sformatf("vector %0d strobe count", v), n0 - b0, VDET[v]);
         if (VDET[v] != 0)
            chk(last0 == stamps[VSI[v]] + LAT, "R1 R2 R4 R7 R8",
                $sformatf("vector %0d start stamp", v), last0,
                stamps[VSI[v]] + LAT);
      end

      // R9: reset in the middle of a legal pattern
      b0 = n0;
      ne = 0;
      tog();
      for (int i = 0; i < 4; i++) begin idle(VH[0][i]); tog(); end
      rst = 1'b1;
      idle(3);
      chk(ent0 == 1'b0, "R9", "entered during reset", ent0, 0);
      rst = 1'b0;
      for (int i = 4; i < 9; i++) begin idle(VH[0][i]); tog(); end
      idle(60);
      chk((n0 - b0) == 0, "R9", "strobe after cut pattern", n0 - b0, 0);

      // R1 R8: legal pattern after reset reports correct start again
      b0 = n0;
      ne = 0;
      tog();
      for (int i = 0; i < 9; i++) begin idle(VH[0][i]); tog(); end
      idle(60);
      chk((n0 - b0) == 1, "R8", "strobe after reset", n0 - b0, 1);
      chk(last0 == stamps[0] + LAT, "R1", "start after reset", last0,
          stamps[0] + LAT);

      // R2: narrow counter saturates, stamps stick at all ones
      idle(300);
      b1 = n1;
      ne = 0;
      tog();
      for (int i = 0; i < 9; i++) begin idle(VH[0][i]); tog(); end
      idle(60);
      chk((n1 - b1) >= 1, "R2", "narrow instance strobe", n1 - b1, 1);
      chk(last1 == 255, "R2", "saturated start stamp", last1, 255);

      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule